// File: doc/BRIEF.md
# SDRAM Row/Column Address Multiplexer

This block converts a system byte address into the values placed on the address pins of a four-bank SDRAM. It handles two phases: in the row phase it presents the row address that goes with an ACTIVE command, and in the column phase it presents the column address and the auto-precharge flag that go with a READ or WRITE command. A command sequencer outside the block picks the phase and registers the command strobe in the same cycle, so the registered outputs here line up with that strobe.

The multiplexed bus is aligned to the column address. Byte address bit 1 always drives bus line 0 in the column phase. The row field therefore begins just above the configured column field, and in interleave mode it begins two bits higher still, because the two bank bits sit directly above the columns. Upper row lines that never share a pin with a column are driven straight from the address, and so is the bank address. A 32-bit memory is wired one line up on the bus, so line 0 is left quiet in that mode. The auto-precharge flag is placed on two adjacent lines, which lets it reach device pin A10 with either wiring. Column width, interleave and memory width are static settings. A setting outside the supported set raises an error flag and forces the outputs to zero.

Top module: `sdram_addr_mux`

## Requirements
- R1: In the column phase with a legal setting, `ma[k]` equals `addr[k+1]` for k = 0..9 (byte bit 1 on line 0, up through byte bit 10 on line 9), whatever the column width. Line 0 is also subject to R6.
- R2: In the column phase with a legal setting, `ma[10]` and `ma[11]` both carry `auto_pre`.
- R3: In the row phase with a legal setting, `ma[k]` equals `addr[B+k]` for k = 0..11. B is `col_bits+1` when `interleave`=0 and `col_bits+3` when `interleave`=1. `auto_pre` has no effect in this phase. Line 0 is also subject to R6.
- R4: `row_hi[i]` equals `addr[B+12+i]` for i = 0..2, and it takes the same value in both phases.
- R5: `bank` equals `addr[B+16:B+15]` when `interleave`=0 and `addr[col_bits+2:col_bits+1]` when `interleave`=1, and it takes the same value in both phases.
- R6: When `mem32`=1, `ma[0]` is 0 in both phases. When `mem32`=0, the bus follows R1 and R3 unchanged.
- R7: `col_bits` values 8 to 11 are legal when `interleave`=0, and only 8 and 9 are legal when `interleave`=1. Any other setting gives `cfg_err`=1 with `ma`, `row_hi` and `bank` all zero. A legal setting gives `cfg_err`=0.
- R8: All outputs are registered. Inputs sampled at one rising edge show up after that edge and not before it. A synchronous `rst`=1 clears every output, `cfg_err` included, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | System byte address |
| phase_col | input | 1 | 1 = column phase, 0 = row phase |
| auto_pre | input | 1 | Auto-precharge request for the column phase |
| col_bits | input | 4 | Configured number of column address bits |
| interleave | input | 1 | Bank bits placed directly above the column field |
| mem32 | input | 1 | 1 = 32-bit memory wiring, 0 = 16-bit |
| ma | output | 12 | Multiplexed address bus |
| row_hi | output | 3 | Upper row lines, not multiplexed |
| bank | output | 2 | Bank address |
| cfg_err | output | 1 | Illegal column width / interleave setting |

## Verification
Every legal pairing of column width and interleave is driven with random addresses under both memory widths. Each address is presented in the row phase and then again in the column phase. Repeating the address across phases shows the directly driven lines (R4, R5) are stable while the multiplexed lines change. Toggling `auto_pre` randomly shows it reaches only the two precharge lines, and only in the column phase. Sweeping the widths separates a fold point taken from the column width from any fixed offset, and the interleave pairs separate the two bank placements. Illegal widths on both sides of each legal range confirm the error flag and the zeroed outputs. An early-sample probe between edges, together with a reset in the middle of the run, confirms the register stage.

// File: rtl/sdram_amux_pkg.sv
package sdram_amux_pkg;

    localparam int MUX_W      = 12;  // multiplexed bus lines
    localparam int COL_LINES  = 10;  // column lines driven from byte bits 1..10
    localparam int AP_LO      = 10;  // lower of the two precharge lines
    localparam int ROW_HI_W   = 3;   // direct upper row lines
    localparam int BANK_W     = 2;   // four banks only
    localparam int COL_MIN    = 8;
    localparam int COL_MAX_FL = 11;  // widest column without interleave
    localparam int COL_MAX_IL = 9;   // widest column with interleave
    localparam int IL_SHIFT   = 2;   // extra row offset in interleave mode

    typedef struct packed {
        logic [3:0] col_bits;
        logic       il;
        logic       w32;
    } amux_cfg_t;

    typedef struct packed {
        logic [MUX_W-1:0]    ma;
        logic [ROW_HI_W-1:0] row_hi;
        logic [BANK_W-1:0]   bank;
    } amux_pins_t;

    function automatic logic cfg_legal(amux_cfg_t c);
        int unsigned cb;
        int unsigned top;
        cb  = int'(c.col_bits);
        top = c.il ? COL_MAX_IL : COL_MAX_FL;
        return (cb >= COL_MIN) && (cb <= top);
    endfunction

endpackage

// File: rtl/amux_cfg_check.sv
module amux_cfg_check
    import sdram_amux_pkg::*;
#(
    parameter int SH_W = 5
) (
    input  amux_cfg_t       cfg,
    output logic            legal,
    output logic [SH_W-1:0] row_base,
    output logic [SH_W-1:0] bank_base
);

    logic [SH_W-1:0] cbw;

    always_comb begin
        legal     = cfg_legal(cfg);
        cbw       = SH_W'(cfg.col_bits);
        row_base  = cbw + SH_W'(cfg.il ? (1 + IL_SHIFT) : 1);
        if (cfg.il)
            bank_base = cbw + SH_W'(1);
        else
            bank_base = row_base + SH_W'(MUX_W + ROW_HI_W);
    end

endmodule

// File: rtl/amux_field_sel.sv
module amux_field_sel
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              phase_col,
    input  logic              auto_pre,
    input  logic              w32,
    input  logic [SH_W-1:0]   row_base,
    input  logic [SH_W-1:0]   bank_base,
    output amux_pins_t        pins
);

    logic [ADDR_W-1:0] row_sh;
    logic [ADDR_W-1:0] bank_sh;
    logic [MUX_W-1:0]  col_ma;
    logic [MUX_W-1:0]  row_ma;
    logic [MUX_W-1:0]  sel_ma;

    // column lines are fixed to the byte address, aligned at bit 1
    for (genvar g = 0; g < COL_LINES; g++) begin : g_col
        assign col_ma[g] = addr[g+1];
    end
    // precharge flag on both adjacent lines
    for (genvar p = AP_LO; p < MUX_W; p++) begin : g_ap
        assign col_ma[p] = auto_pre;
    end

    always_comb begin
        row_sh  = addr >> row_base;
        bank_sh = addr >> bank_base;
        row_ma  = row_sh[MUX_W-1:0];
        sel_ma  = phase_col ? col_ma : row_ma;
        if (w32)
            sel_ma[0] = 1'b0;
        pins.ma     = sel_ma;
        pins.row_hi = row_sh[MUX_W +: ROW_HI_W];
        pins.bank   = bank_sh[BANK_W-1:0];
    end

endmodule

// File: rtl/amux_out_reg.sv
module amux_out_reg
    import sdram_amux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       legal,
    input  amux_pins_t nxt,
    output amux_pins_t q,
    output logic       err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            err <= 1'b0;
        end else if (!legal) begin
            q   <= '0;
            err <= 1'b1;
        end else begin
            q   <= nxt;
            err <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                phase_col,
    input  logic                auto_pre,
    input  logic [3:0]          col_bits,
    input  logic                interleave,
    input  logic                mem32,
    output logic [MUX_W-1:0]    ma,
    output logic [ROW_HI_W-1:0] row_hi,
    output logic [BANK_W-1:0]   bank,
    output logic                cfg_err
);

    localparam int SH_W = $clog2(ADDR_W);

    amux_cfg_t       cfg;
    logic            legal;
    logic [SH_W-1:0] row_base;
    logic [SH_W-1:0] bank_base;
    amux_pins_t      nxt;
    amux_pins_t      q;

    assign cfg.col_bits = col_bits;
    assign cfg.il       = interleave;
    assign cfg.w32      = mem32;

    amux_cfg_check #(.SH_W(SH_W)) cfg_i (
        .cfg       (cfg),
        .legal     (legal),
        .row_base  (row_base),
        .bank_base (bank_base)
    );

    amux_field_sel #(.ADDR_W(ADDR_W), .SH_W(SH_W)) sel_i (
        .addr      (addr),
        .phase_col (phase_col),
        .auto_pre  (auto_pre),
        .w32       (mem32),
        .row_base  (row_base),
        .bank_base (bank_base),
        .pins      (nxt)
    );

    amux_out_reg reg_i (
        .clk   (clk),
        .rst   (rst),
        .legal (legal),
        .nxt   (nxt),
        .q     (q),
        .err   (cfg_err)
    );

    assign ma     = q.ma;
    assign row_hi = q.row_hi;
    assign bank   = q.bank;

endmodule

// File: rtl/sdram_addr_mux_chk.sv
module sdram_addr_mux_chk
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                phase_col,
    input logic                auto_pre,
    input logic [3:0]          col_bits,
    input logic                interleave,
    input logic                mem32,
    input logic [MUX_W-1:0]    ma,
    input logic [ROW_HI_W-1:0] row_hi,
    input logic [BANK_W-1:0]   bank,
    input logic                cfg_err
);

    logic              past_ok;
    logic              rst_d;
    logic [ADDR_W-1:0] above_col;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
        rst_d <= rst;
    end

    assign above_col = addr >> ({1'b0, col_bits} + 5'd1);

    p_col_lines_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(phase_col) && !cfg_err |-> ma[9:1] == $past(addr[10:2]));

    p_ap_pair_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(phase_col) && !cfg_err |->
            (ma[11] == $past(auto_pre)) && (ma[10] == $past(auto_pre)));

    p_row_fold_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(phase_col) && !$past(interleave) && !$past(mem32) && !cfg_err
            |-> ma[0] == $past(above_col[0]));

    p_bank_il_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(interleave) && !cfg_err |-> bank == $past(above_col[1:0]));

    p_w32_line0_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(mem32) |-> ma[0] == 1'b0);

    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (ma == '0) && (row_hi == '0) && (bank == '0));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst_d |-> (ma == '0) && (row_hi == '0) && (bank == '0) && !cfg_err);

endmodule

bind sdram_addr_mux sdram_addr_mux_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/sdram_addr_mux_tb_top.sv
module sdram_addr_mux_tb_top;

    typedef struct {
        logic        legal;
        logic        col;
        logic        w32;
        logic [11:0] ma;
        logic [2:0]  row_hi;
        logic [1:0]  bank;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        phase_col = 1'b0;
    logic        auto_pre = 1'b0;
    logic [3:0]  col_bits = 4'd8;
    logic        interleave = 1'b0;
    logic        mem32 = 1'b0;
    logic [11:0] ma;
    logic [2:0]  row_hi;
    logic [1:0]  bank;
    logic        cfg_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t q[$];
    exp_t prev;
    logic prev_ok = 1'b0;

    always #5 clk = ~clk;

    sdram_addr_mux dut_i (
        .clk(clk), .rst(rst), .addr(addr), .phase_col(phase_col),
        .auto_pre(auto_pre), .col_bits(col_bits), .interleave(interleave),
        .mem32(mem32), .ma(ma), .row_hi(row_hi), .bank(bank), .cfg_err(cfg_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(logic [31:0] a, logic col, logic ap,
                                   int cb, logic il, logic w);
        exp_t e;
        int   b;
        e.col = col;
        e.w32 = w;
        e.legal = il ? (cb == 8 || cb == 9) : (cb >= 8 && cb <= 11);
        e.ma = '0; e.row_hi = '0; e.bank = '0;
        if (!e.legal) return e;
        b = il ? cb + 3 : cb + 1;
        for (int k = 0; k < 12; k++)
            e.ma[k] = col ? ((k < 10) ? a[k+1] : ap) : a[b+k];
        if (w) e.ma[0] = 1'b0;
        for (int i = 0; i < 3; i++) e.row_hi[i] = a[b+12+i];
        for (int i = 0; i < 2; i++) e.bank[i] = il ? a[cb+1+i] : a[b+15+i];
        return e;
    endfunction

    function automatic logic same_out(exp_t e);
        return (ma === e.ma) && (row_hi === e.row_hi) && (bank === e.bank)
            && (cfg_err === !e.legal);
    endfunction

    task automatic drive(logic [31:0] a, logic col, logic ap, int cb, logic il, logic w);
        @(negedge clk);
        addr = a; phase_col = col; auto_pre = ap;
        col_bits = 4'(cb); interleave = il; mem32 = w;
        q.push_back(model(a, col, ap, cb, il, w));
        #1;
        if (prev_ok) check("R8 early sample holds previous", 32'(same_out(prev)), 32'd1);
    endtask

    // monitor: one item per edge that follows a push
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("R7 cfg_err", 32'(cfg_err), 32'(!e.legal));
                if (!e.legal) begin
                    check("R7 outputs zero", {17'd0, ma, row_hi, bank}, 32'd0);
                end else begin
                    if (e.col) begin
                        check("R1 column lines", 32'(ma[9:1]), 32'(e.ma[9:1]));
                        check("R2 precharge lines", 32'(ma[11:10]), 32'(e.ma[11:10]));
                    end else begin
                        check("R3 row lines", 32'(ma[11:1]), 32'(e.ma[11:1]));
                    end
                    if (e.w32) check("R6 line0 quiet", 32'(ma[0]), 32'd0);
                    else if (e.col) check("R1 line0", 32'(ma[0]), 32'(e.ma[0]));
                    else check("R3 line0", 32'(ma[0]), 32'(e.ma[0]));
                    check("R4 row_hi", 32'(row_hi), 32'(e.row_hi));
                    check("R5 bank", 32'(bank), 32'(e.bank));
                end
                prev = e;
                prev_ok = 1'b1;
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic        ap;
        // reset with busy inputs
        addr = 32'hFFFF_FFFF; auto_pre = 1'b1; phase_col = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset clears", {16'd0, ma, row_hi, bank, cfg_err}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // legal sweep: each address in row then column phase
        for (int cb = 8; cb <= 11; cb++)
            for (int il = 0; il < 2; il++)
                for (int w = 0; w < 2; w++) begin
                    if (il == 1 && cb > 9) continue;
                    for (int n = 0; n < 6; n++) begin
                        a  = $urandom;
                        ap = 1'($urandom);
                        drive(a, 1'b0, ap, cb, 1'(il), 1'(w));
                        drive(a, 1'b1, ap, cb, 1'(il), 1'(w));
                        drive(a, 1'b1, ~ap, cb, 1'(il), 1'(w));
                    end
                    drive(32'hFFFF_FFFF, 1'b0, 1'b0, cb, 1'(il), 1'(w));
                    drive(32'h0000_0000, 1'b1, 1'b1, cb, 1'(il), 1'(w));
                end

        // illegal settings on both sides of each range
        drive(32'hDEAD_BEEF, 1'b1, 1'b1, 7, 1'b0, 1'b0);
        drive(32'hDEAD_BEEF, 1'b0, 1'b1, 12, 1'b0, 1'b1);
        drive(32'hDEAD_BEEF, 1'b1, 1'b1, 0, 1'b0, 1'b0);
        drive(32'hDEAD_BEEF, 1'b1, 1'b1, 15, 1'b0, 1'b0);
        drive(32'hDEAD_BEEF, 1'b0, 1'b1, 7, 1'b1, 1'b0);
        drive(32'hDEAD_BEEF, 1'b1, 1'b1, 10, 1'b1, 1'b0);
        drive(32'hDEAD_BEEF, 1'b1, 1'b0, 11, 1'b1, 1'b1);
        drive(32'h1234_5678, 1'b1, 1'b1, 9, 1'b1, 1'b0);

        // reset in the middle of the run
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        prev_ok = 1'b0;
        @(posedge clk);
        #1;
        check("R8 mid-run reset clears", {16'd0, ma, row_hi, bank, cfg_err}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(32'hA5A5_5A5A, 1'b0, 1'b1, 9, 1'b0, 1'b0);
        drive(32'hA5A5_5A5A, 1'b1, 1'b1, 9, 1'b0, 1'b0);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule